// File: doc/BRIEF.md
# External Interrupt Synchronizer and Flagger

This block takes four asynchronous maskable interrupt lines and one non-maskable line into the core clock domain. Every line first passes through two flip-flops in series. A rising edge on the synchronized level then starts a fixed delay line, and at the end of that line a per-source pending flag is set.

Each cycle, an arbiter looks at the pending flags together with a global enable and a per-source enable vector. It picks the winning source and emits a one-cycle acknowledge pulse carrying that source's interrupt number. The flag of the taken source clears on the same clock edge.

Everything runs on the core clock. The acknowledge and number are plain outputs with no handshake. The consumer must take the pulse in the cycle it appears.

Top module: `irq_sync_flagger`

## Requirements
- R1: While reset is asserted and after its release, with all lines low, `ack_o` is 0, `ack_num_o` is 0 and no source is pending.
- R2: A line that rises between two clock edges is captured on the first edge (edge 0). `ack_o` then goes high after edge 5, so it can first be seen after the sixth edge. A change inside the setup/hold window may add one edge. Internally, the pending flag is set three edges after the second synchronizer stage goes high, and the acknowledge comes at least one edge after the flag.
- R3: Only a low-to-high transition of a synchronized line raises a request. A line held high produces exactly one acknowledge.
- R4: A maskable source whose bit in `src_en_i` is 0 stays pending and is not acknowledged. It is acknowledged after the first clock edge at which its enable is 1.
- R5: While `glob_en_i` is 0, no maskable source is acknowledged. Pending maskable requests survive until the global enable returns.
- R6: The non-maskable line ignores both enables, wins over every maskable source, and is reported as number 1.
- R7: Line `ext_irq_i[i]` is reported as number 4+i. Among eligible maskable sources, the lowest number is taken first. One source is taken per cycle.
- R8: The taken source's flag clears on the acknowledging edge. A new request for that source that reaches its flag on the same edge leaves the flag set, which gives a second acknowledge.
- R9: `ack_o` is high for one cycle per taken request. `ack_num_o` is 0 whenever `ack_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ext_irq_i | input | 4 | Asynchronous maskable lines, bit i is number 4+i |
| nmi_i | input | 1 | Asynchronous non-maskable line |
| glob_en_i | input | 1 | Global enable for maskable sources |
| src_en_i | input | 4 | Per-source enable, bit i gates number 4+i |
| ack_o | output | 1 | One-cycle acknowledge pulse |
| ack_num_o | output | 3 | Number of the source taken, 0 when idle |

## Verification
The bench checks the ports every cycle against its own model. A lost or stuck flag shows up at the ports in one of three ways:
- as a missing acknowledge six edges after an input rise;
- as a duplicate acknowledge the cycle after the correct one;
- as a pulse that appears while the source is masked.

Each of these is visible within one cycle of the expected acknowledge. A wrong priority or number encoding corrupts `ack_num_o` in the first cycle where two sources are pending together. A delay stage that is off by one moves the pulse by a whole cycle, and the fixed-latency checks catch that.

// File: rtl/irq_sync_pkg.sv
package irq_sync_pkg;
  localparam int unsigned N_MASK_DEF    = 4;
  localparam int unsigned FIRST_NUM_DEF = 4;
  localparam int unsigned POST_DLY_DEF  = 3;
  localparam int unsigned NMI_NUM_DEF   = 1;
  localparam int unsigned NUM_W_DEF     = 3;
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/irq_edge_pipe.sv
module irq_edge_pipe #(
  parameter int unsigned W   = 5,
  parameter int unsigned DLY = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] set_o
);
  localparam int unsigned STG = (DLY > 1) ? DLY - 1 : 1;

  logic [W-1:0] prev_q;
  logic [W-1:0] rise;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  assign rise = level_i & ~prev_q;

  generate
    if (DLY > 1) begin : g_delay
      logic [STG-1:0][W-1:0] stg_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_q <= '0;
        end else begin
          stg_q[0] <= rise;
          for (int s = 1; s < int'(STG); s++) stg_q[s] <= stg_q[s-1];
        end
      end
      assign set_o = stg_q[STG-1];
    end else begin : g_direct
      assign set_o = rise;
    end
  endgenerate
endmodule

// File: rtl/irq_flag_arb.sv
module irq_flag_arb #(
  parameter int unsigned N_MASK    = 4,
  parameter int unsigned FIRST_NUM = 4,
  parameter int unsigned NMI_NUM   = 1,
  parameter int unsigned NUM_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MASK:0]   set_i,
  input  logic              glob_en_i,
  input  logic [N_MASK-1:0] src_en_i,
  output logic [N_MASK:0]   flag_o,
  output logic              ack_o,
  output logic [NUM_W-1:0]  num_o
);
  localparam int unsigned NSRC = N_MASK + 1;

  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] grant;
  logic [NUM_W-1:0] num_d;
  logic            ack_q;
  logic [NUM_W-1:0] num_q;

  always_comb begin
    elig[0] = flag_q[0];
    for (int i = 0; i < int'(N_MASK); i++)
      elig[i+1] = flag_q[i+1] & glob_en_i & src_en_i[i];
  end

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (elig[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    num_d = '0;
    if (grant[0]) num_d = NUM_W'(NMI_NUM);
    for (int i = 0; i < int'(N_MASK); i++)
      if (grant[i+1]) num_d = NUM_W'(FIRST_NUM + i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      ack_q  <= 1'b0;
      num_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~grant) | set_i;
      ack_q  <= |grant;
      num_q  <= num_d;
    end
  end

  assign flag_o = flag_q;
  assign ack_o  = ack_q;
  assign num_o  = num_q;
endmodule

// File: rtl/irq_sync_flagger.sv
module irq_sync_flagger
  import irq_sync_pkg::*;
#(
  parameter int unsigned N_MASK    = N_MASK_DEF,
  parameter int unsigned FIRST_NUM = FIRST_NUM_DEF,
  parameter int unsigned POST_DLY  = POST_DLY_DEF,
  parameter int unsigned NMI_NUM   = NMI_NUM_DEF,
  parameter int unsigned NUM_W     = NUM_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MASK-1:0] ext_irq_i,
  input  logic              nmi_i,
  input  logic              glob_en_i,
  input  logic [N_MASK-1:0] src_en_i,
  output logic              ack_o,
  output logic [NUM_W-1:0]  ack_num_o
);
  localparam int unsigned NSRC = N_MASK + 1;

  logic [NSRC-1:0] raw_lines;
  logic [NSRC-1:0] sync_q;
  logic [NSRC-1:0] set_pulse;
  logic [NSRC-1:0] flag_q;

  assign raw_lines = {ext_irq_i, nmi_i};

  irq_sync2 #(.W(NSRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_lines),
    .sync_o  (sync_q)
  );

  irq_edge_pipe #(.W(NSRC), .DLY(POST_DLY)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (sync_q),
    .set_o   (set_pulse)
  );

  irq_flag_arb #(
    .N_MASK    (N_MASK),
    .FIRST_NUM (FIRST_NUM),
    .NMI_NUM   (NMI_NUM),
    .NUM_W     (NUM_W)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_pulse),
    .glob_en_i (glob_en_i),
    .src_en_i  (src_en_i),
    .flag_o    (flag_q),
    .ack_o     (ack_o),
    .num_o     (ack_num_o)
  );
endmodule

// File: rtl/irq_sync_flagger_chk.sv
module irq_sync_flagger_chk #(
  parameter int unsigned N_MASK    = 4,
  parameter int unsigned FIRST_NUM = 4,
  parameter int unsigned NMI_NUM   = 1,
  parameter int unsigned NUM_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glob_en_i,
  input logic [N_MASK-1:0] src_en_i,
  input logic [N_MASK:0]   sync_q,
  input logic [N_MASK:0]   flag_q,
  input logic              ack_o,
  input logic [NUM_W-1:0]  ack_num_o
);
  // R6
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q[0] |=> (ack_o && ack_num_o == NUM_W'(NMI_NUM)));

  // R5
  glob_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en_i |=> !(ack_o && ack_num_o != NUM_W'(NMI_NUM)));

  // R9
  idle_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> ack_num_o == '0);

  // R2
  nmi_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q[0]) |-> ##3 flag_q[0]);

  genvar k;
  generate
    for (k = 0; k < N_MASK; k++) begin : g_src
      // R2
      set_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_q[k+1]) |-> ##3 flag_q[k+1]);

      // R4
      src_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en_i[k] |=> !(ack_o && ack_num_o == NUM_W'(FIRST_NUM + k)));

      // R2
      flag_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && ack_num_o == NUM_W'(FIRST_NUM + k)) |-> $past(flag_q[k+1]));
    end
  endgenerate
endmodule

bind irq_sync_flagger irq_sync_flagger_chk #(
  .N_MASK    (N_MASK),
  .FIRST_NUM (FIRST_NUM),
  .NMI_NUM   (NMI_NUM),
  .NUM_W     (NUM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glob_en_i (glob_en_i),
  .src_en_i  (src_en_i),
  .sync_q    (sync_q),
  .flag_q    (flag_q),
  .ack_o     (ack_o),
  .ack_num_o (ack_num_o)
);

// File: tb/irq_sync_flagger_test.sv
module irq_sync_flagger_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_irq_i = '0;
  logic       nmi_i = 1'b0;
  logic       glob_en_i = 1'b1;
  logic [3:0] src_en_i = 4'hF;
  logic       ack_o;
  logic [2:0] ack_num_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Model state, index 0 is the non-maskable line
  logic [4:0] m_s1, m_s2, m_s2d, m_d1, m_d2, m_flag;
  logic       m_ack;
  logic [2:0] m_num;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_sync_flagger uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_irq_i (ext_irq_i),
    .nmi_i     (nmi_i),
    .glob_en_i (glob_en_i),
    .src_en_i  (src_en_i),
    .ack_o     (ack_o),
    .ack_num_o (ack_num_o)
  );

  function automatic logic [4:0] pick(input logic [4:0] fl, input logic ge, input logic [3:0] se);
    logic [4:0] el;
    el = fl & {se & {4{ge}}, 1'b1};
    for (int i = 0; i < 5; i++) if (el[i]) return 5'(1 << i);
    return 5'd0;
  endfunction

  function automatic logic [2:0] code_of(input logic [4:0] g);
    if (g[0]) return 3'd1;
    for (int i = 1; i < 5; i++) if (g[i]) return 3'(3 + i);
    return 3'd0;
  endfunction

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_s2d = '0; m_d1 = '0; m_d2 = '0; m_flag = '0;
    m_ack = 1'b0; m_num = '0;
  endtask

  task automatic model_step();
    logic [4:0] g;
    logic [4:0] rise;
    rise   = m_s2 & ~m_s2d;
    g      = pick(m_flag, glob_en_i, src_en_i);
    m_flag = (m_flag & ~g) | m_d2;
    m_d2   = m_d1;
    m_d1   = rise;
    m_s2d  = m_s2;
    m_s2   = m_s1;
    m_s1   = {ext_irq_i, nmi_i};
    m_ack  = |g;
    m_num  = code_of(g);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: model follows the edge, ports compared at the falling edge
  task automatic cyc(input string tag);
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    check({tag, " ack"}, 32'(ack_o), 32'(m_ack));
    check({tag, " num"}, 32'(ack_num_o), 32'(m_num));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
      $finish;
    end
  end

  initial begin
    int first;
    model_reset();
    @(negedge clk);
    // R1 reset state
    idle(3, "R1");
    check("R1 ack in reset", 32'(ack_o), 0);
    rst_n = 1'b1;
    idle(10, "R1");
    check("R1 idle num", 32'(ack_num_o), 0);

    // R2 latency, R7 number of ext 0, R9 single pulse, R3 no retrigger
    ext_irq_i[0] = 1'b1;
    first = 0;
    for (int i = 1; i <= 9; i++) begin
      cyc("R2");
      if (ack_o && first == 0) begin
        first = i;
        check("R7 number ext0", 32'(ack_num_o), 4);
      end
    end
    check("R2 latency", 32'((first == 6) || (first == 7)), 1);
    idle(20, "R3");
    check("R3 held level", 32'(ack_o), 0);
    ext_irq_i[0] = 1'b0;
    idle(4, "R9");

    // R4 per-source enable postpones
    src_en_i[1] = 1'b0;
    ext_irq_i[1] = 1'b1;
    idle(15, "R4");
    check("R4 masked", 32'(ack_o), 0);
    src_en_i[1] = 1'b1;
    cyc("R4");
    check("R4 released ack", 32'(ack_o), 1);
    check("R4 released num", 32'(ack_num_o), 5);
    ext_irq_i[1] = 1'b0;
    idle(4, "R4");

    // R5 global enable, R6 NMI ignores it
    glob_en_i = 1'b0;
    ext_irq_i[2] = 1'b1;
    nmi_i = 1'b1;
    idle(6, "R6");
    check("R6 nmi under mask ack", 32'(ack_o), 1);
    check("R6 nmi number", 32'(ack_num_o), 1);
    nmi_i = 1'b0;
    idle(10, "R5");
    check("R5 gated", 32'(ack_o), 0);
    glob_en_i = 1'b1;
    cyc("R5");
    check("R5 released num", 32'(ack_num_o), 6);
    ext_irq_i[2] = 1'b0;
    idle(4, "R5");

    // R6/R7 priority: NMI, then 6, then 7 on consecutive cycles
    nmi_i = 1'b1; ext_irq_i[3] = 1'b1; ext_irq_i[2] = 1'b1;
    idle(6, "R7");
    check("R6 first", 32'(ack_num_o), 1);
    cyc("R7");
    check("R7 second", 32'(ack_num_o), 6);
    cyc("R7");
    check("R7 third", 32'(ack_num_o), 7);
    nmi_i = 1'b0; ext_irq_i = '0;
    idle(6, "R7");

    // R8 re-set on the clearing edge: acks NMI, 4, 4
    nmi_i = 1'b1; ext_irq_i[0] = 1'b1;
    cyc("R8");
    ext_irq_i[0] = 1'b0;
    cyc("R8");
    ext_irq_i[0] = 1'b1;
    idle(4, "R8");
    check("R8 nmi", 32'(ack_num_o), 1);
    cyc("R8");
    check("R8 first ack", 32'(ack_num_o), 4);
    cyc("R8");
    check("R8 re-set ack", 32'({ack_o, ack_num_o}), 32'({1'b1, 3'd4}));
    cyc("R8");
    check("R8 then idle", 32'(ack_o), 0);
    nmi_i = 1'b0; ext_irq_i = '0;
    idle(6, "R8");

    // Random traffic against the model (R2-R9)
    void'($urandom(32'h1d2c));
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < 4; b++)
        if (($urandom % 8) == 0) ext_irq_i[b] = ~ext_irq_i[b];
      if (($urandom % 12) == 0) nmi_i = ~nmi_i;
      if (($urandom % 20) == 0) glob_en_i = ~glob_en_i;
      if (($urandom % 16) == 0) src_en_i = 4'($urandom);
      cyc("R7/R9 random");
    end

    done = 1;
    report();
    $finish;
  end
endmodule